// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator

This block produces one pulse-width-modulated output from a free-running 16-bit phase accumulator. On every clock cycle an active increment (the base unit) is added to the accumulator modulo 65536. Each carry out of the accumulator starts a new output period, so the output frequency is f_clk × base / 65536. Within a period the output is high while the upper byte of the accumulator is below an 8-bit on-time value, which sets the duty cycle.

Software-side values are first written into shadow registers with a write strobe. An update strobe arms a transfer, and the transfer into the active registers takes place at the next accumulator carry. A period therefore never mixes old and new settings. The transfer also happens at once while the block is disabled or while the active increment is zero, since no carry can come in either case. An optional clamp keeps a written increment between 1 and range/32 (2048). This prevents a stalled output and keeps at least 32 reachable duty levels. A flag reports whether the clamp changed the most recent write.

Top module: `phase_pwm_gen`

## Requirements
- R1: After reset the output is low, the clamp flag is 0, both active registers and both shadow registers hold 0, and no transfer is armed.
- R2: While enable is high, each clock adds the active base unit to the 16-bit accumulator modulo 65536. A carry out of bit 15 marks the end of a period.
- R3: The output is high exactly when enable was high at the last clock edge, the active base unit is non-zero and accumulator bits [15:8] are below the active on-time (unsigned). An active on-time of 0 gives a constant low output.
- R4: With an active base unit of 0 the accumulator does not move and the output stays low.
- R5: A clock edge with the write strobe high stores the (possibly clamped) base unit and the on-time into the shadow registers. This has no effect on the output until a transfer happens.
- R6: The update strobe arms a transfer. An armed transfer copies shadow to active at the first later clock edge where the accumulator carries, enable is low, or the active base unit is 0, and the transfer is then disarmed. An update strobe at the edge of a transfer keeps the transfer armed.
- R7: A write at the same edge as a transfer has the transfer take the shadow contents from before that write.
- R8: A clock edge with enable low clears the accumulator to 0, and the output is low after it. Counting resumes from 0 when enable returns.
- R9: With clamp enable high, a written base unit of 0 is stored as 1 and one above 2048 is stored as 2048.
- R10: With clamp enable low, the written base unit is stored unchanged, including 0 and values above 2048.
- R11: Every write sets the clamp flag to 1 if the clamp changed the base unit and to 0 otherwise. Without a write the flag holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; low clears the accumulator |
| clampEn | input | 1 | Selects the clamped base unit for writes |
| writeStrobe | input | 1 | Captures baseUnitIn and onTimeIn into shadow |
| baseUnitIn | input | 16 | Requested increment per clock |
| onTimeIn | input | 8 | Requested on-time compare value |
| updateStrobe | input | 1 | Arms a shadow-to-active transfer |
| pwmOut | output | 1 | PWM output |
| clampHit | output | 1 | Last write was modified by the clamp |

## Verification
Several functions can fall in the same cycle. An update strobe can coincide with the accumulator carry, and a shadow write can coincide with the transfer that an earlier update armed. The bench provokes both by sweeping the strobe offset across whole periods, and by writing a new on-time on every cycle after one update. A behavioural reference model, built from the requirements as integer state and updated at each clock edge, judges every cycle. The transfer must fall on the first carry after the arming edge, and it must carry the pre-write shadow contents.

// File: rtl/phase_pwm_pkg.sv
package phase_pwm_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadActive;  // copy shadow into active at this edge
    logic clearAcc;    // hold accumulator at zero and stop output
  } pwmStrobe_t;
endpackage

// File: rtl/phase_pwm_clamp.sv
module phase_pwm_clamp #(
  parameter int ACC_W     = 16,
  parameter int MIN_STEPS = 32
) (
  input  logic             clampEn,
  input  logic [ACC_W-1:0] rawBase,
  output logic [ACC_W-1:0] usedBase,
  output logic             modified
);
  localparam int RANGE = 2 ** ACC_W;
  localparam int MAX_INT = RANGE / MIN_STEPS;
  localparam logic [ACC_W-1:0] MAX_BASE = ACC_W'(MAX_INT);

  logic [ACC_W-1:0] limited;
  logic [ACC_W-1:0] clamped;

  generate
    if (MIN_STEPS > 1) begin : g_upper
      always_comb limited = (rawBase > MAX_BASE) ? MAX_BASE : rawBase;
    end else begin : g_noupper
      always_comb limited = rawBase;
    end
  endgenerate

  always_comb begin
    clamped  = (rawBase == '0) ? ACC_W'(1) : limited;
    usedBase = clampEn ? clamped : rawBase;
    modified = clampEn && (clamped != rawBase);
  end
endmodule

// File: rtl/phase_pwm_ctrl.sv
module phase_pwm_ctrl
  import phase_pwm_pkg::*;
#(
  parameter int ACC_W     = 16,
  parameter int DUTY_W    = 8,
  parameter int MIN_STEPS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              clampEn,
  input  logic              writeStrobe,
  input  logic [ACC_W-1:0]  baseUnitIn,
  input  logic [DUTY_W-1:0] onTimeIn,
  input  logic              updateStrobe,
  input  logic              wrapNext,
  input  logic              baseZero,
  output pwmStrobe_t        strobe,
  output logic [ACC_W-1:0]  shadowBase,
  output logic [DUTY_W-1:0] shadowOn,
  output logic              clampHit
);
  localparam int MAX_INT = (2 ** ACC_W) / MIN_STEPS;
  localparam logic [ACC_W-1:0] MAX_BASE = ACC_W'(MAX_INT);

  logic [ACC_W-1:0] usedBase;
  logic             modified;
  logic             pendingQ;
  logic             loadNow;

  phase_pwm_clamp #(.ACC_W(ACC_W), .MIN_STEPS(MIN_STEPS)) clamp_i (
    .clampEn  (clampEn),
    .rawBase  (baseUnitIn),
    .usedBase (usedBase),
    .modified (modified)
  );

  // A transfer waits for a period boundary, or goes at once when no boundary can come
  always_comb begin
    loadNow           = pendingQ && (wrapNext || !enable || baseZero);
    strobe.loadActive = loadNow;
    strobe.clearAcc   = !enable;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowBase <= '0;
      shadowOn   <= '0;
      clampHit   <= 1'b0;
      pendingQ   <= 1'b0;
    end else begin
      if (writeStrobe) begin
        shadowBase <= usedBase;
        shadowOn   <= onTimeIn;
        clampHit   <= modified;
      end
      pendingQ <= updateStrobe || (pendingQ && !loadNow);
    end
  end

  generate
    if (MIN_STEPS > 1) begin : g_range_chk
      assert_clamp_range_R9: assert property (@(posedge clk) disable iff (!rstN)
        (writeStrobe && clampEn) |=> (shadowBase != '0 && shadowBase <= MAX_BASE));
    end
  endgenerate

  assert_raw_pass_R10: assert property (@(posedge clk) disable iff (!rstN)
    (writeStrobe && !clampEn) |=> (shadowBase == $past(baseUnitIn)));

  assert_arm_R6: assert property (@(posedge clk) disable iff (!rstN)
    updateStrobe |=> pendingQ);

  assert_flag_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !writeStrobe |=> $stable(clampHit));
endmodule

// File: rtl/phase_pwm_datapath.sv
module phase_pwm_datapath
  import phase_pwm_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwmStrobe_t        strobe,
  input  logic [ACC_W-1:0]  shadowBase,
  input  logic [DUTY_W-1:0] shadowOn,
  output logic              wrapNext,
  output logic              baseZero,
  output logic              pwmOut
);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  activeBase;
  logic [DUTY_W-1:0] activeOn;
  logic              runQ;
  logic [SUM_W-1:0]  sum;
  logic [DUTY_W-1:0] phaseHi;

  always_comb begin
    sum      = {1'b0, acc} + {1'b0, activeBase};
    wrapNext = sum[ACC_W];
    baseZero = (activeBase == '0);
    phaseHi  = acc[ACC_W-1 -: DUTY_W];
    pwmOut   = runQ && !baseZero && (phaseHi < activeOn);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc        <= '0;
      activeBase <= '0;
      activeOn   <= '0;
      runQ       <= 1'b0;
    end else begin
      runQ <= !strobe.clearAcc;
      acc  <= strobe.clearAcc ? '0 : sum[ACC_W-1:0];
      if (strobe.loadActive) begin
        activeBase <= shadowBase;
        activeOn   <= shadowOn;
      end
    end
  end

  assert_stall_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clearAcc && baseZero) |=> $stable(acc));

  assert_zero_duty_R3: assert property (@(posedge clk) disable iff (!rstN)
    (activeOn == '0) |-> !pwmOut);

  assert_load_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (activeBase != $past(activeBase)) |-> $past(strobe.loadActive));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.clearAcc) |-> (acc == '0 && !pwmOut));
endmodule

// File: rtl/phase_pwm_gen.sv
module phase_pwm_gen
  import phase_pwm_pkg::*;
#(
  parameter int ACC_W     = 16,
  parameter int DUTY_W    = 8,
  parameter int MIN_STEPS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              clampEn,
  input  logic              writeStrobe,
  input  logic [ACC_W-1:0]  baseUnitIn,
  input  logic [DUTY_W-1:0] onTimeIn,
  input  logic              updateStrobe,
  output logic              pwmOut,
  output logic              clampHit
);
  pwmStrobe_t        strobe;
  logic [ACC_W-1:0]  shadowBase;
  logic [DUTY_W-1:0] shadowOn;
  logic              wrapNext;
  logic              baseZero;

  phase_pwm_ctrl #(.ACC_W(ACC_W), .DUTY_W(DUTY_W), .MIN_STEPS(MIN_STEPS)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .clampEn      (clampEn),
    .writeStrobe  (writeStrobe),
    .baseUnitIn   (baseUnitIn),
    .onTimeIn     (onTimeIn),
    .updateStrobe (updateStrobe),
    .wrapNext     (wrapNext),
    .baseZero     (baseZero),
    .strobe       (strobe),
    .shadowBase   (shadowBase),
    .shadowOn     (shadowOn),
    .clampHit     (clampHit)
  );

  phase_pwm_datapath #(.ACC_W(ACC_W), .DUTY_W(DUTY_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .shadowBase (shadowBase),
    .shadowOn   (shadowOn),
    .wrapNext   (wrapNext),
    .baseZero   (baseZero),
    .pwmOut     (pwmOut)
  );
endmodule

// File: tb/phase_pwm_gen_tb_top.sv
`timescale 1ns/1ps
module phase_pwm_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        clampEn = 1'b0;
  logic        writeStrobe = 1'b0;
  logic [15:0] baseUnitIn = '0;
  logic [7:0]  onTimeIn = '0;
  logic        updateStrobe = 1'b0;
  logic        pwmOut;
  logic        clampHit;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string phaseTag = "R1";

  // reference state
  int mAcc = 0, mBase = 0, mOn = 0, sBase = 0, sOn = 0;
  bit mPend = 0, mRun = 0, mHit = 0;

  always #2.5 clk = ~clk;

  phase_pwm_gen dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .clampEn(clampEn),
    .writeStrobe(writeStrobe), .baseUnitIn(baseUnitIn), .onTimeIn(onTimeIn),
    .updateStrobe(updateStrobe), .pwmOut(pwmOut), .clampHit(clampHit)
  );

  function automatic int clampOf(int raw, bit en);
    if (!en) return raw;
    if (raw == 0) return 1;
    if (raw > 2048) return 2048;
    return raw;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mAcc = 0; mBase = 0; mOn = 0; sBase = 0; sOn = 0;
      mPend = 0; mRun = 0; mHit = 0;
    end else begin
      bit wrap, load;
      int nb, no;
      wrap = (mAcc + mBase) >= 65536;
      load = mPend && (wrap || !enable || mBase == 0);
      nb = mBase; no = mOn;
      if (load) begin nb = sBase; no = sOn; end
      mAcc = enable ? (mAcc + mBase) % 65536 : 0;
      mBase = nb; mOn = no;
      mPend = updateStrobe ? 1'b1 : (load ? 1'b0 : mPend);
      if (writeStrobe) begin
        int v;
        v = clampOf(int'(baseUnitIn), clampEn);
        mHit = (v != int'(baseUnitIn));
        sBase = v; sOn = int'(onTimeIn);
      end
      mRun = enable;
    end
  end

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got=%0d exp=%0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      int expOut;
      expOut = (mRun && mBase != 0 && (mAcc >> 8) < mOn) ? 1 : 0;
      check(phaseTag, "pwmOut", int'(pwmOut), expOut);
      check("R11", "clampHit", int'(clampHit), int'(mHit));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeRegs(int base, int on, bit clamp, bit upd);
    @(negedge clk);
    baseUnitIn = 16'(base); onTimeIn = 8'(on); clampEn = clamp;
    writeStrobe = 1'b1; updateStrobe = upd;
    @(negedge clk);
    writeStrobe = 1'b0; updateStrobe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired got=1 exp=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(4);
    // R1: reset values
    check("R1", "pwmOut in reset", int'(pwmOut), 0);
    check("R1", "clampHit in reset", int'(clampHit), 0);
    @(negedge clk); rstN = 1'b1;
    idle(2);
    check("R1", "pwmOut after reset", int'(pwmOut), 0);

    // R5: shadow write alone leaves the output untouched
    phaseTag = "R5";
    enable = 1'b1;
    writeRegs(1024, 128, 1'b1, 1'b0);
    idle(100);
    check("R5", "pwmOut before transfer", int'(pwmOut), 0);

    // R2/R3: transfer and run at 64-cycle period, 50 percent
    phaseTag = "R2";
    writeRegs(1024, 128, 1'b1, 1'b1);
    idle(200);

    // R6: update strobe swept across period offsets, including the carry cycle
    phaseTag = "R6";
    for (int k = 0; k < 24; k++) begin
      writeRegs(1024, 32 + 8 * k, 1'b0, 1'b1);
      idle(60 + (k % 7));
    end

    // R7: writes every cycle after one update, overlapping the transfer edge
    phaseTag = "R7";
    writeRegs(1024, 200, 1'b0, 1'b1);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      baseUnitIn = 16'(1024); onTimeIn = 8'(i * 3); writeStrobe = 1'b1;
    end
    @(negedge clk); writeStrobe = 1'b0;
    idle(150);

    // R9: clamp of zero and of a large increment
    phaseTag = "R9";
    writeRegs(0, 128, 1'b1, 1'b1);
    check("R9", "clampHit after write 0", int'(clampHit), 1);
    idle(100);
    writeRegs(50000, 64, 1'b1, 1'b1);
    check("R9", "clampHit after write 50000", int'(clampHit), 1);
    idle(20);
    // R8: disable lets the armed transfer go and clears the phase
    phaseTag = "R8";
    @(negedge clk); enable = 1'b0;
    idle(3);
    check("R8", "pwmOut while disabled", int'(pwmOut), 0);
    @(negedge clk); enable = 1'b1;
    phaseTag = "R9";
    idle(200);

    // R10: raw pass-through with the clamp off
    phaseTag = "R10";
    writeRegs(32768, 100, 1'b0, 1'b1);
    check("R10", "clampHit raw write", int'(clampHit), 0);
    idle(100);

    // R4: zero increment freezes the output low
    phaseTag = "R4";
    writeRegs(0, 255, 1'b0, 1'b1);
    idle(300);
    check("R4", "pwmOut with zero base", int'(pwmOut), 0);
    phaseTag = "R6";
    writeRegs(3000, 200, 1'b0, 1'b1);
    idle(200);

    // R11: in-range write with clamp on clears the flag
    phaseTag = "R11";
    writeRegs(2048, 77, 1'b1, 1'b0);
    check("R11", "clampHit in-range write", int'(clampHit), 0);
    writeRegs(1, 77, 1'b1, 1'b1);
    idle(100);

    // R8: disable mid-run, then restart
    phaseTag = "R8";
    writeRegs(2000, 150, 1'b0, 1'b1);
    idle(57);
    @(negedge clk); enable = 1'b0;
    idle(5);
    @(negedge clk); enable = 1'b1;
    idle(120);

    // R3: duty extremes
    phaseTag = "R3";
    writeRegs(2048, 0, 1'b0, 1'b1);
    idle(100);
    check("R3", "pwmOut with zero on-time", int'(pwmOut), 0);
    writeRegs(2048, 255, 1'b0, 1'b1);
    idle(100);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule